// File: doc/BRIEF.md
# Complementary PWM Output Guard

This block stands between a CPU register bus and the register file of a six-output complementary PWM timer, and between that timer's outputs and the pins. On the bus side it decides, for each access, whether the register file may see a write and what comes back on a read. A single access-enable bit, kept in the block's own control register, locks out a fixed set of 21 protected timer registers. The double-buffer registers and all other addresses stay open.

On the pin side it produces six output enables. These are dropped, which puts the pins in high impedance, when any of four active-low external shutdown inputs is asserted. They are also dropped when the main clock is found to have stopped. An independent backup clock watches a toggle flag driven by the main clock. The shutdown is held in a latch that only a software clear removes, because the pin state after a clock restart cannot be trusted.

Top module: `pwm_guard`

## Requirements
- R1: After reset the access-enable bit is 1, the shutdown latch is 0 and all six entries of `pinOe` are 1. A read of the control register at address 0x30 then returns 0x0001: bit 0 is the enable and bit 1 is the latch.
- R2: While access is enabled, a write to a protected address raises `regWe` in the same cycle. A read returns `regRdata` unchanged.
- R3: While access is disabled, a write to a protected address leaves `regWe` low.
- R4: While access is disabled, a read of a protected address returns all ones on `cpuRdata`.
- R5: Exactly 21 addresses are protected: 0x00–0x07, 0x10–0x17 and 0x20–0x24. All other addresses, apart from 0x30, pass through untouched.
- R6: Buffer and other unprotected addresses, such as 0x08, 0x09, 0x19 and 0x40, are written and read normally whatever the enable bit holds.
- R7: Driving any one of the four `extShdnN` inputs low drops all six `pinOe` bits on the third main-clock rising edge after the change.
- R8: The shutdown latch stays set after the inputs return high. A control-register write with bit 1 set clears it, but only when all four synchronised inputs are high and no clock stop is pending.
- R9: With the main clock halted, all `pinOe` bits drop after no toggle has been seen for 8 backup-clock cycles. This works with no main-clock edge at all.
- R10: After the main clock restarts, `pinOe` stays low and control bit 1 reads 1 until software clears the latch.
- R11: A write to 0x30 always loads bit 0 into the enable, whatever its current value. The control register is never part of the protected set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| bakClk | input | 1 | Independent backup clock for stop detection |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| cpuSel | input | 1 | Bus access strobe |
| cpuWr | input | 1 | 1 for write, 0 for read |
| cpuAddr | input | 8 | Register address |
| cpuCtrlBits | input | 2 | Low write-data bits: bit 0 enable, bit 1 clear |
| regRdata | input | 16 | Read data from the timer register file |
| cpuRdata | output | 16 | Read data returned to the CPU |
| regWe | output | 1 | Gated write strobe to the timer register file |
| extShdnN | input | 4 | Active-low external shutdown requests |
| pinOe | output | 6 | Output enables for the six PWM pins, 0 means high impedance |

## Verification
The bus gating is combinational, so `regWe` and `cpuRdata` are checked one time unit after the inputs are driven, inside the same cycle. A control-register write takes effect at the next rising edge, and its result is read back after that edge. For an external input, two synchroniser stages plus the latch put the output change on the third main-clock edge. The bench checks that the enables are still high after two edges and low after the third. The clock-stop path is sampled only after a wait well beyond the sync-plus-8 backup-cycle window, and the restart is checked after enough main-clock edges for the stop flag to clear.

// File: rtl/pwm_guard_pkg.sv
package pwm_guard_pkg;
  localparam int CTRL_BITS = 2;
  localparam int EN_BIT    = 0;
  localparam int CLR_BIT   = 1;

  typedef struct packed {
    logic rdFill;
    logic rdCtrl;
    logic clrReq;
  } guardStrobe_t;
endpackage

// File: rtl/pwm_guard_sync.sv
module pwm_guard_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= {STAGES{{WIDTH{RST_VAL}}}};
    else       stage <= {stage[STAGES-2:0], din};
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/pwm_guard_ctrl.sv
module pwm_guard_ctrl
  import pwm_guard_pkg::*;
#(
  parameter int AW          = 8,
  parameter int NUM_CH      = 2,
  parameter int CH_BASE     = 0,
  parameter int CH_STRIDE   = 16,
  parameter int CH_PROT     = 8,
  parameter int SHARED_BASE = 32,
  parameter int SHARED_CNT  = 5,
  parameter int CTRL_ADDR   = 48
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [AW-1:0]        cpuAddr,
  input  logic [CTRL_BITS-1:0] cpuCtrlBits,
  output logic                 accessEn,
  output logic                 protHit,
  output logic                 ctrlHit,
  output logic                 regWe,
  output guardStrobe_t         strobe
);
  localparam int NUM_HIT = NUM_CH + 1;

  logic [NUM_HIT-1:0] hitVec;
  logic wrAcc, rdAcc, locked;

  // one window per timer channel, sized by CH_PROT
  genvar gC;
  generate
    for (gC = 0; gC < NUM_CH; gC++) begin : g_chan
      localparam int LO = CH_BASE + gC * CH_STRIDE;
      localparam int HI = LO + CH_PROT;
      assign hitVec[gC] = (int'(cpuAddr) >= LO) && (int'(cpuAddr) < HI);
    end
  endgenerate

  assign hitVec[NUM_CH] = (int'(cpuAddr) >= SHARED_BASE) &&
                          (int'(cpuAddr) < SHARED_BASE + SHARED_CNT);

  assign protHit = |hitVec;
  assign ctrlHit = (int'(cpuAddr) == CTRL_ADDR);
  assign wrAcc   = cpuSel && cpuWr;
  assign rdAcc   = cpuSel && !cpuWr;
  assign locked  = protHit && !accessEn;

  always_comb begin
    regWe         = wrAcc && !ctrlHit && !locked;
    strobe.rdFill = rdAcc && locked;
    strobe.rdCtrl = rdAcc && ctrlHit;
    strobe.clrReq = wrAcc && ctrlHit && cpuCtrlBits[CLR_BIT];
  end

  // the enable itself is never locked, otherwise lockout could not be undone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 accessEn <= 1'b1;
    else if (wrAcc && ctrlHit) accessEn <= cpuCtrlBits[EN_BIT];
  end
endmodule

// File: rtl/pwm_guard_dp.sv
module pwm_guard_dp
  import pwm_guard_pkg::*;
#(
  parameter int DW          = 16,
  parameter int N_EXT       = 4,
  parameter int N_OUT       = 6,
  parameter int STOP_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             bakClk,
  input  logic             rstN,
  input  logic [N_EXT-1:0] extShdnN,
  input  guardStrobe_t     strobe,
  input  logic             accessEn,
  input  logic [DW-1:0]    regRdata,
  output logic [DW-1:0]    cpuRdata,
  output logic [N_OUT-1:0] pinOe,
  output logic             shutLatch,
  output logic [N_EXT-1:0] syncN,
  output logic             stopDet
);
  localparam int CW = $clog2(STOP_CYCLES + 1);

  logic          mainTgl, tglS, tglPrev, tglSeen, stopS, extAct;
  logic [CW-1:0] idleCnt;
  logic [DW-1:0] ctrlWord;

  // external requests into the main domain
  pwm_guard_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_extSync (
    .clk(clk), .rstN(rstN), .din(extShdnN), .dout(syncN)
  );

  // heartbeat from the main domain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mainTgl <= 1'b0;
    else       mainTgl <= ~mainTgl;
  end

  // backup domain watches the heartbeat
  pwm_guard_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tglSync (
    .clk(bakClk), .rstN(rstN), .din(mainTgl), .dout(tglS)
  );

  always_ff @(posedge bakClk or negedge rstN) begin
    if (!rstN) begin
      tglPrev <= 1'b0;
      idleCnt <= '0;
    end else begin
      tglPrev <= tglS;
      if (tglSeen)                          idleCnt <= '0;
      else if (idleCnt != CW'(STOP_CYCLES)) idleCnt <= idleCnt + 1'b1;
    end
  end

  assign tglSeen = tglS ^ tglPrev;
  assign stopDet = (idleCnt == CW'(STOP_CYCLES));

  // stop flag back into the main domain so the latch remembers it
  pwm_guard_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stopSync (
    .clk(clk), .rstN(rstN), .din(stopDet), .dout(stopS)
  );

  assign extAct = |(~syncN);

  // set wins over clear, so a clear with any cause active does nothing
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 shutLatch <= 1'b0;
    else if (extAct || stopS)  shutLatch <= 1'b1;
    else if (strobe.clrReq)    shutLatch <= 1'b0;
  end

  // stopDet bypasses the main clock so a dead clock still releases the pins
  assign pinOe = {N_OUT{~(shutLatch | stopDet)}};

  always_comb begin
    ctrlWord          = '0;
    ctrlWord[EN_BIT]  = accessEn;
    ctrlWord[CLR_BIT] = shutLatch;
    if (strobe.rdFill)      cpuRdata = '1;
    else if (strobe.rdCtrl) cpuRdata = ctrlWord;
    else                    cpuRdata = regRdata;
  end
endmodule

// File: rtl/pwm_guard.sv
module pwm_guard
  import pwm_guard_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int N_EXT       = 4,
  parameter int N_OUT       = 6,
  parameter int NUM_CH      = 2,
  parameter int CH_BASE     = 0,
  parameter int CH_STRIDE   = 16,
  parameter int CH_PROT     = 8,
  parameter int SHARED_BASE = 32,
  parameter int SHARED_CNT  = 5,
  parameter int CTRL_ADDR   = 48,
  parameter int STOP_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 bakClk,
  input  logic                 rstN,
  input  logic                 cpuSel,
  input  logic                 cpuWr,
  input  logic [AW-1:0]        cpuAddr,
  input  logic [CTRL_BITS-1:0] cpuCtrlBits,
  input  logic [DW-1:0]        regRdata,
  output logic [DW-1:0]        cpuRdata,
  output logic                 regWe,
  input  logic [N_EXT-1:0]     extShdnN,
  output logic [N_OUT-1:0]     pinOe
);
  guardStrobe_t     strobe;
  logic             accessEn, protHit, ctrlHit, shutLatch, stopDet, clrReq;
  logic [N_EXT-1:0] syncN;

  assign clrReq = strobe.clrReq;

  pwm_guard_ctrl #(
    .AW(AW), .NUM_CH(NUM_CH), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE),
    .CH_PROT(CH_PROT), .SHARED_BASE(SHARED_BASE), .SHARED_CNT(SHARED_CNT),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuCtrlBits(cpuCtrlBits), .accessEn(accessEn), .protHit(protHit),
    .ctrlHit(ctrlHit), .regWe(regWe), .strobe(strobe)
  );

  pwm_guard_dp #(
    .DW(DW), .N_EXT(N_EXT), .N_OUT(N_OUT), .STOP_CYCLES(STOP_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .bakClk(bakClk), .rstN(rstN), .extShdnN(extShdnN),
    .strobe(strobe), .accessEn(accessEn), .regRdata(regRdata),
    .cpuRdata(cpuRdata), .pinOe(pinOe), .shutLatch(shutLatch),
    .syncN(syncN), .stopDet(stopDet)
  );
endmodule

// File: rtl/pwm_guard_chk.sv
module pwm_guard_chk
  import pwm_guard_pkg::*;
#(
  parameter int DW    = 16,
  parameter int N_EXT = 4,
  parameter int N_OUT = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cpuSel,
  input logic                 cpuWr,
  input logic [CTRL_BITS-1:0] cpuCtrlBits,
  input logic [DW-1:0]        cpuRdata,
  input logic                 regWe,
  input logic [N_OUT-1:0]     pinOe,
  input logic                 accessEn,
  input logic                 protHit,
  input logic                 ctrlHit,
  input logic                 shutLatch,
  input logic [N_EXT-1:0]     syncN,
  input logic                 clrReq
);
  a_r3_drop_write: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWr && protHit && !accessEn) |-> !regWe);

  a_r4_fill_read: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWr && protHit && !accessEn) |-> (cpuRdata == '1));

  a_r11_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWr && ctrlHit) |=> (accessEn == $past(cpuCtrlBits[EN_BIT])));

  a_r7_latch_sets: assert property (@(posedge clk) disable iff (!rstN)
    !(&syncN) |=> shutLatch);

  a_r7_pins_off: assert property (@(posedge clk) disable iff (!rstN)
    shutLatch |-> (pinOe == '0));

  a_r8_clear_gated: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shutLatch) |-> ($past(clrReq) && $past(&syncN)));
endmodule

bind pwm_guard pwm_guard_chk #(.DW(DW), .N_EXT(N_EXT), .N_OUT(N_OUT)) u_chk (.*);

// File: tb/pwm_guard_bench.sv
module pwm_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BAK_HALF   = 17;
  localparam logic [15:0] REG_VAL = 16'h5A3C;

  logic        clk = 1'b0, bakClk = 1'b0, rstN = 1'b0, clkRun = 1'b1;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [7:0]  cpuAddr = '0;
  logic [1:0]  cpuCtrlBits = '0;
  logic [15:0] regRdata = REG_VAL;
  logic [15:0] cpuRdata;
  logic        regWe;
  logic [3:0]  extShdnN = 4'hF;
  logic [5:0]  pinOe;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always begin
    #(CLK_PERIOD / 2);
    if (clkRun) clk = ~clk;
  end
  always #(BAK_HALF) bakClk = ~bakClk;

  pwm_guard u_pwm_guard (
    .clk(clk), .bakClk(bakClk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuCtrlBits(cpuCtrlBits), .regRdata(regRdata),
    .cpuRdata(cpuRdata), .regWe(regWe), .extShdnN(extShdnN), .pinOe(pinOe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic busIdle;
    cpuSel = 1'b0; cpuWr = 1'b0; cpuAddr = '0; cpuCtrlBits = '0;
  endtask

  task automatic writeProbe(input logic [7:0] a, input logic expWe, input string tag);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = a;
    #1 chk(tag, 32'(regWe), 32'(expWe));
    busIdle();
  endtask

  task automatic readProbe(input logic [7:0] a, input logic [15:0] expD, input string tag);
    cpuSel = 1'b1; cpuWr = 1'b0; cpuAddr = a;
    #1 chk(tag, 32'(cpuRdata), 32'(expD));
    busIdle();
  endtask

  task automatic ctrlWrite(input logic [1:0] bits);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = 8'h30; cpuCtrlBits = bits;
    step();
    busIdle();
  endtask

  task automatic t_reset;
    chk("R1 pinOe after reset", 32'(pinOe), 32'h3F);
    readProbe(8'h30, 16'h0001, "R1 control word after reset");
  endtask

  task automatic t_enabled;
    writeProbe(8'h05, 1'b1, "R2 protected write enabled");
    writeProbe(8'h21, 1'b1, "R2 shared write enabled");
    readProbe(8'h13, REG_VAL, "R2 protected read enabled");
  endtask

  task automatic t_lockout;
    ctrlWrite(2'b00);
    readProbe(8'h30, 16'h0000, "R11 enable cleared");
    writeProbe(8'h05, 1'b0, "R3 write dropped 0x05");
    writeProbe(8'h22, 1'b0, "R3 write dropped 0x22");
    readProbe(8'h00, 16'hFFFF, "R4 fill on 0x00");
    readProbe(8'h24, 16'hFFFF, "R4 fill on 0x24");
  endtask

  task automatic t_exempt;
    writeProbe(8'h08, 1'b1, "R6 buffer 0x08 write");
    writeProbe(8'h19, 1'b1, "R6 buffer 0x19 write");
    writeProbe(8'h40, 1'b1, "R6 other 0x40 write");
    readProbe(8'h09, REG_VAL, "R6 buffer 0x09 read");
  endtask

  task automatic t_membership;
    int filled = 0;
    for (int a = 0; a < 256; a++) begin
      if (a != 8'h30) begin
        cpuSel = 1'b1; cpuWr = 1'b0; cpuAddr = 8'(a);
        #1 if (cpuRdata == 16'hFFFF) filled++;
      end
    end
    busIdle();
    chk("R5 protected count", 32'(filled), 32'd21);
    readProbe(8'h07, 16'hFFFF, "R5 edge 0x07 protected");
    readProbe(8'h17, 16'hFFFF, "R5 edge 0x17 protected");
    readProbe(8'h25, REG_VAL, "R5 edge 0x25 open");
    readProbe(8'h1F, REG_VAL, "R5 edge 0x1F open");
    ctrlWrite(2'b01);
    readProbe(8'h30, 16'h0001, "R11 enable set again");
    writeProbe(8'h05, 1'b1, "R11 write restored");
  endtask

  task automatic t_ext_shutdown;
    for (int k = 0; k < 4; k++) begin
      extShdnN[k] = 1'b0;
      step(); step();
      chk("R7 pins still on after two edges", 32'(pinOe), 32'h3F);
      step();
      chk("R7 pins off after third edge", 32'(pinOe), 32'h00);
      extShdnN[k] = 1'b1;
      step(); step(); step();
      ctrlWrite(2'b11);
      chk("R8 cleared with inputs idle", 32'(pinOe), 32'h3F);
    end
  endtask

  task automatic t_sticky;
    extShdnN[2] = 1'b0;
    repeat (5) step();
    ctrlWrite(2'b11);
    chk("R8 clear refused while input low", 32'(pinOe), 32'h00);
    extShdnN[2] = 1'b1;
    repeat (4) step();
    chk("R8 latch holds after release", 32'(pinOe), 32'h00);
    readProbe(8'h30, 16'h0003, "R8 latch visible in control word");
    ctrlWrite(2'b11);
    chk("R8 clear accepted", 32'(pinOe), 32'h3F);
    readProbe(8'h30, 16'h0001, "R8 latch bit cleared");
  endtask

  task automatic t_clock_stop;
    clkRun = 1'b0;
    #(BAK_HALF * 2 * 20);
    chk("R9 pins off with clock halted", 32'(pinOe), 32'h00);
    clkRun = 1'b1;
    repeat (40) step();
    chk("R10 pins stay off after restart", 32'(pinOe), 32'h00);
    readProbe(8'h30, 16'h0003, "R10 latch set after restart");
    ctrlWrite(2'b11);
    chk("R10 released by clear", 32'(pinOe), 32'h3F);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    step();
    t_reset();
    t_enabled();
    t_lockout();
    t_exempt();
    t_membership();
    t_ext_shutdown();
    t_sticky();
    t_clock_stop();
    finishRun();
  end
endmodule